// File: doc/BRIEF.md
# Systolic Horner Polynomial Evaluator

The block evaluates a fixed polynomial of degree `DEG` at a stream of sample points. It applies Horner's rule on a linear chain of `2*DEG` registered cells. The cells come in pairs. The first cell of a pair multiplies the running value by the sample point. The second cell adds one coefficient. The chain is seeded with the leading coefficient, and the coefficients are folded in from the highest order down to the constant term.

Each sample point moves down the chain next to its own partial result, so every multiply sees the matching point. A valid flag travels with each partial result. One new point can enter on every clock cycle. Once the chain has filled, one finished value leaves per cycle. All arithmetic is two's complement at width `DW` and wraps on overflow.

Coefficients are written one at a time through a small write port. A write moves down the chain as a wavefront in step with the samples. The effect is that every sample is evaluated with a single, consistent coefficient set, even while a write is under way.

Top module: `horner_array`

## Requirements
- R1: `out_y` equals the Horner evaluation of the stored coefficients a_DEG..a_0 at the sample's `in_x`. Each product keeps only its low `DW` bits, and each sum wraps modulo 2^DW.
- R2: A sample presented with `in_valid` high in cycle c appears with `out_valid` high in cycle c+2*DEG, exactly, with its result on `out_y`.
- R3: Samples may be presented in consecutive cycles with no gap. Each one yields its own result in consecutive output cycles.
- R4: A cycle with `in_valid` low yields a cycle with `out_valid` low 2*DEG cycles later, so gaps in the input stream are kept.
- R5: A cycle with `coef_we` high and `coef_sel` = j, for 0 <= j <= DEG, sets coefficient a_j (a_j multiplies x^j) to `coef_val`. Every sample presented in a later cycle uses the new value.
- R6: A sample presented in the same cycle as a coefficient write is evaluated with the complete old coefficient set. So is every sample presented earlier that is still in flight.
- R7: A write with `coef_sel` greater than DEG changes no coefficient and has no effect on any result.
- R8: While `rst_n` is low, `out_valid` and `out_y` are zero. All coefficients reset to zero, so samples evaluated before any write give zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample point is presented this cycle |
| in_x | input | DW | Sample point, two's complement |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | $clog2(DEG+1) | Power of x whose coefficient is written |
| coef_val | input | DW | Coefficient value, two's complement |
| out_valid | output | 1 | `out_y` holds a finished result |
| out_y | output | DW | Polynomial value, two's complement |

## Verification
A coefficient write and a sample can land in the same cycle. So can a write and samples that are still in flight at every depth of the chain. The bench does this in directed cycles, where the constant term and the leading coefficient are written alongside a sample. It also does it over thousands of random cycles, where writes at random indices, including out-of-range ones, fall among a dense random sample stream.

The bench model computes each expected result from its coefficient copy as that copy stands before the same cycle's write is applied, and only then updates the copy. A sample that picked up a new coefficient at any cell therefore shows up as a value mismatch 2*DEG cycles later.

// File: rtl/horner_pkg.sv
package horner_pkg;

   // Number of registered cells: one multiply and one add per order.
   function automatic int stage_count(input int deg);
      return 2 * deg;
   endfunction

   // Width of the coefficient selector for a given degree.
   function automatic int sel_width(input int deg);
      return (deg < 1) ? 1 : $clog2(deg + 1);
   endfunction

endpackage

// File: rtl/hrn_mul_cell.sv
// Multiply stage: scales the running value by the point that travels with it.
module hrn_mul_cell #(
   parameter int DW = 16,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          v_i,
   input  logic [DW-1:0] x_i,
   input  logic [DW-1:0] acc_i,
   input  logic          wv_i,
   input  logic [IW-1:0] wi_i,
   input  logic [DW-1:0] wd_i,
   output logic          v_o,
   output logic [DW-1:0] x_o,
   output logic [DW-1:0] acc_o,
   output logic          wv_o,
   output logic [IW-1:0] wi_o,
   output logic [DW-1:0] wd_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_o   <= 1'b0;
         x_o   <= '0;
         acc_o <= '0;
         wv_o  <= 1'b0;
         wi_o  <= '0;
         wd_o  <= '0;
      end else begin
         v_o   <= v_i;
         x_o   <= x_i;
         acc_o <= acc_i * x_i;
         wv_o  <= wv_i;
         wi_o  <= wi_i;
         wd_o  <= wd_i;
      end
   end

endmodule

// File: rtl/hrn_add_cell.sv
// Add stage: owns one coefficient and captures writes from the passing wavefront.
module hrn_add_cell #(
   parameter int DW   = 16,
   parameter int IW   = 3,
   parameter int CIDX = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          v_i,
   input  logic [DW-1:0] x_i,
   input  logic [DW-1:0] acc_i,
   input  logic          wv_i,
   input  logic [IW-1:0] wi_i,
   input  logic [DW-1:0] wd_i,
   output logic          v_o,
   output logic [DW-1:0] x_o,
   output logic [DW-1:0] acc_o,
   output logic          wv_o,
   output logic [IW-1:0] wi_o,
   output logic [DW-1:0] wd_o
);

   logic [DW-1:0] coef_q;
   logic          hit;

   assign hit = wv_i && (wi_i == IW'(CIDX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coef_q <= '0;
         v_o    <= 1'b0;
         x_o    <= '0;
         acc_o  <= '0;
         wv_o   <= 1'b0;
         wi_o   <= '0;
         wd_o   <= '0;
      end else begin
         if (hit) coef_q <= wd_i;
         v_o   <= v_i;
         x_o   <= x_i;
         acc_o <= acc_i + coef_q;
         wv_o  <= wv_i;
         wi_o  <= wi_i;
         wd_o  <= wd_i;
      end
   end

endmodule

// File: rtl/horner_array.sv
module horner_array #(
   parameter  int DW  = 16,
   parameter  int DEG = 4,
   localparam int IW  = horner_pkg::sel_width(DEG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_x,
   input  logic          coef_we,
   input  logic [IW-1:0] coef_sel,
   input  logic [DW-1:0] coef_val,
   output logic          out_valid,
   output logic [DW-1:0] out_y
);

   localparam int NSTG = horner_pkg::stage_count(DEG);

   if (DEG < 1) begin : g_bad_deg
      $error("horner_array: DEG must be at least 1");
   end
   if (DW < 2) begin : g_bad_dw
      $error("horner_array: DW must be at least 2");
   end

   // Leading coefficient seeds the chain at stage 0.
   logic [DW-1:0] lead_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     lead_q <= '0;
      else if (coef_we && (coef_sel == IW'(DEG)))     lead_q <= coef_val;
   end

   logic          sv  [0:NSTG];
   logic [DW-1:0] sx  [0:NSTG];
   logic [DW-1:0] sa  [0:NSTG];
   logic          swv [0:NSTG];
   logic [IW-1:0] swi [0:NSTG];
   logic [DW-1:0] swd [0:NSTG];

   assign sv[0]  = in_valid;
   assign sx[0]  = in_x;
   assign sa[0]  = lead_q;
   assign swv[0] = coef_we;
   assign swi[0] = coef_sel;
   assign swd[0] = coef_val;

   for (genvar k = 1; k <= DEG; k++) begin : g_pair
      hrn_mul_cell #(.DW(DW), .IW(IW)) u_mul (
         .clk   (clk),          .rst_n (rst_n),
         .v_i   (sv[2*k-2]),    .x_i   (sx[2*k-2]),   .acc_i (sa[2*k-2]),
         .wv_i  (swv[2*k-2]),   .wi_i  (swi[2*k-2]),  .wd_i  (swd[2*k-2]),
         .v_o   (sv[2*k-1]),    .x_o   (sx[2*k-1]),   .acc_o (sa[2*k-1]),
         .wv_o  (swv[2*k-1]),   .wi_o  (swi[2*k-1]),  .wd_o  (swd[2*k-1])
      );
      hrn_add_cell #(.DW(DW), .IW(IW), .CIDX(DEG - k)) u_add (
         .clk   (clk),          .rst_n (rst_n),
         .v_i   (sv[2*k-1]),    .x_i   (sx[2*k-1]),   .acc_i (sa[2*k-1]),
         .wv_i  (swv[2*k-1]),   .wi_i  (swi[2*k-1]),  .wd_i  (swd[2*k-1]),
         .v_o   (sv[2*k]),      .x_o   (sx[2*k]),     .acc_o (sa[2*k]),
         .wv_o  (swv[2*k]),     .wi_o  (swi[2*k]),    .wd_o  (swd[2*k])
      );
   end

   assign out_valid = sv[NSTG];
   assign out_y     = sa[NSTG];

   logic unused_tail;
   assign unused_tail = ^{sx[NSTG], swv[NSTG], swi[NSTG], swd[NSTG]};

endmodule

// File: rtl/horner_array_chk.sv
module horner_array_chk #(
   parameter int DW  = 16,
   parameter int DEG = 4
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic                                in_valid,
   input logic                                coef_we,
   input logic [horner_pkg::sel_width(DEG)-1:0] coef_sel,
   input logic [DW-1:0]                       coef_val,
   input logic                                out_valid,
   input logic [DW-1:0]                       out_y,
   input logic [DW-1:0]                       lead_coef
);

   localparam int NSTG = horner_pkg::stage_count(DEG);

   // Independent record of presented samples, one bit per cycle of latency.
   logic [NSTG-1:0] vq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vq <= '0;
      else        vq <= {vq[NSTG-2:0], in_valid};
   end

   // R2 / R4: output flag follows the input flag exactly 2*DEG cycles later.
   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vq[NSTG-1]);

   // R5: a write to the top order lands in the leading coefficient.
   p_lead_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (coef_we && int'(coef_sel) == DEG) |=> lead_coef == $past(coef_val));

   // R7: an out-of-range selector leaves the leading coefficient alone.
   p_bad_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (coef_we && int'(coef_sel) > DEG) |=> $stable(lead_coef));

   // R8: leaving reset, outputs and coefficient are cleared.
   p_reset_clear_r8: assert property (@(posedge clk)
      $rose(rst_n) |-> (!out_valid && out_y == '0 && lead_coef == '0));

endmodule

bind horner_array horner_array_chk #(.DW(DW), .DEG(DEG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .coef_we   (coef_we),
   .coef_sel  (coef_sel),
   .coef_val  (coef_val),
   .out_valid (out_valid),
   .out_y     (out_y),
   .lead_coef (lead_q)
);

// File: tb/sim_horner_array.sv
`timescale 1ns/1ps
module sim_horner_array;
   localparam int DW   = 16;
   localparam int DEG  = 4;
   localparam int IW   = $clog2(DEG + 1);
   localparam int LAT  = 2 * DEG;
   localparam int RING = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_x = '0;
   logic          coef_we = 1'b0;
   logic [IW-1:0] coef_sel = '0;
   logic [DW-1:0] coef_val = '0;
   logic          out_valid;
   logic [DW-1:0] out_y;

   horner_array #(.DW(DW), .DEG(DEG)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
      .coef_we(coef_we), .coef_sel(coef_sel), .coef_val(coef_val),
      .out_valid(out_valid), .out_y(out_y)
   );

   always #4 clk = ~clk;

   int            n_run = 0;
   int            n_fail = 0;
   int            cyc = 0;
   bit            done = 0;
   logic [DW-1:0] mc [0:DEG];
   logic          ev [RING];
   logic [DW-1:0] ey [RING];
   string         et [RING];

   function automatic logic [DW-1:0] ref_y(input logic [DW-1:0] x);
      logic [DW-1:0] acc;
      acc = mc[DEG];
      for (int j = DEG - 1; j >= 0; j--) begin
         acc = acc * x;
         acc = acc + mc[j];
      end
      return acc;
   endfunction

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
      end
   endtask

   // One cycle: check this cycle's outputs, then drive this cycle's inputs.
   task automatic step(input logic v, input logic [DW-1:0] x, input logic we,
                       input logic [IW-1:0] sel, input logic [DW-1:0] val, input string tag);
      int slot;
      @(negedge clk);
      slot = cyc % RING;
      check(et[slot], DW'(out_valid), DW'(ev[slot]));
      if (ev[slot]) check(et[slot], out_y, ey[slot]);
      in_valid = v; in_x = x; coef_we = we; coef_sel = sel; coef_val = val;
      slot = (cyc + LAT) % RING;
      ev[slot] = v;
      ey[slot] = ref_y(x);
      et[slot] = v ? tag : "R4";
      if (we && int'(sel) <= DEG) mc[sel] = val;
      cyc++;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < RING; i++) begin ev[i] = 1'b0; ey[i] = '0; et[i] = "R4"; end
      for (int j = 0; j <= DEG; j++) mc[j] = '0;

      // R8: reset state
      repeat (3) @(negedge clk);
      check("R8", DW'(out_valid), '0);
      check("R8", out_y, '0);
      rst_n = 1'b1;

      // R8: zero coefficients give zero
      step(1, 16'd5, 0, 0, 0, "R8");
      step(1, 16'hFFFD, 0, 0, 0, "R8");
      step(1, 16'h7FFF, 0, 0, 0, "R8");

      // R5: load a4..a0 = 3, -2, 5, 1, 7
      step(0, 0, 1, 3'd4, 16'd3, "R5");
      step(0, 0, 1, 3'd3, 16'hFFFE, "R5");
      step(0, 0, 1, 3'd2, 16'd5, "R5");
      step(0, 0, 1, 3'd1, 16'd1, "R5");
      step(0, 0, 1, 3'd0, 16'd7, "R5");

      // R3 / R1: back-to-back corner points
      step(1, 16'h0000, 0, 0, 0, "R3");
      step(1, 16'h0001, 0, 0, 0, "R3");
      step(1, 16'hFFFF, 0, 0, 0, "R3");
      step(1, 16'h7FFF, 0, 0, 0, "R1");
      step(1, 16'h8000, 0, 0, 0, "R1");
      step(1, 16'h0002, 0, 0, 0, "R3");

      // R2 / R4: gaps kept
      step(1, 16'd3, 0, 0, 0, "R2");
      step(0, 16'd9, 0, 0, 0, "R4");
      step(1, 16'hFFFE, 0, 0, 0, "R2");
      step(0, 16'd1, 0, 0, 0, "R4");
      step(0, 16'd1, 0, 0, 0, "R4");
      step(1, 16'd11, 0, 0, 0, "R2");

      // R7: out-of-range selectors with samples alongside
      step(1, 16'd2, 1, 3'd5, 16'h1234, "R7");
      step(1, 16'd3, 1, 3'd6, 16'h5555, "R7");
      step(1, 16'd4, 1, 3'd7, 16'hAAAA, "R7");
      step(1, 16'd2, 0, 0, 0, "R7");

      // R6: write and sample in the same cycle, then the next sample sees the new value
      step(1, 16'd2, 1, 3'd0, 16'd100, "R6");
      step(1, 16'd2, 1, 3'd4, 16'hFFF9, "R6");
      step(1, 16'd2, 0, 0, 0, "R6");
      step(1, 16'd3, 1, 3'd2, 16'd17, "R6");
      step(1, 16'd3, 0, 0, 0, "R5");

      // R1: random stream with random writes
      for (int i = 0; i < 3000; i++) begin
         step(($urandom % 4) != 0, DW'($urandom), ($urandom % 8) == 0,
              IW'($urandom), DW'($urandom), "R1");
      end

      for (int i = 0; i < LAT + 2; i++) step(0, 0, 0, 0, 0, "R4");

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule